// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block gathers event pulses from an eight-socket network-offload engine into a single active-low interrupt line for a host processor. Each socket owns an event register and an enable mask; an event pulse is recorded only if the socket's mask allows it at that moment. A per-socket summary word shows which sockets hold any recorded event. A separate group of eight common events is latched unconditionally. The output decision uses the summary word under a summary mask and the common events under a common mask.

The host reaches every register through a small synchronous port: one write strobe, a 12-bit address and byte-wide data, with reads returned combinationally. Address bits [11:8] select a block. Block 0 holds the shared registers. Block n+1 holds socket n. Recorded events are cleared by writing ones.

Once the line has released, a 16-bit hold-off interval, counted in clock cycles, must elapse before the line can drop again. This spaces interrupts apart when further causes are already waiting.

Top module: `nic_irq_agg`

## Requirements
- R1: After reset the common events, common mask, summary, summary mask and interval all read 0x00, every socket mask reads 0xFF, every socket event register reads 0x00, and `irq_n` is high.
- R2: A socket event pulse on bit b sets bit b of that socket's event register at the next clock edge only if mask bit b is 1 at that edge. Bit 0 marks connection establishment and bit 3 marks a timeout.
- R3: A host write to a socket event register (offset 0x02) clears the bits written as 1 and leaves the bits written as 0 unchanged. A write can never set a bit.
- R4: A common event pulse on bit b sets bit b of the common event register (offset 0x15) whatever the common mask (offset 0x16) holds. Writing 1 to a bit clears it.
- R5: Summary bit n (offset 0x17) reads 1 exactly when socket n's event register is nonzero. Writes to the summary register have no effect.
- R6: When the hold-off timer is idle, `irq_n` goes low one clock edge after an enabled common bit or an enabled summary bit becomes set. An event pulse sampled at edge E therefore drives `irq_n` low after edge E+1. The summary mask is at offset 0x18.
- R7: `irq_n` returns high one clock edge after the last enabled pending bit is cleared.
- R8: After `irq_n` returns high with interval I loaded, it stays high for at least I+1 clock cycles. If a cause is pending throughout, it goes low after exactly I+1 cycles; I = 0 gives one high cycle.
- R9: If an event pulse and a host write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: The interval is read and written as a high byte at block 0 offset 0x13 and a low byte at offset 0x14. Within a socket block, the mask sits at offset 0x2C. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address: [11:8] block, [7:0] offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| sock_evt_i | input | 64 | Socket event pulses; bits [8n+7:8n] belong to socket n |
| com_evt_i | input | 8 | Common event pulses |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle the assertions check the following:
- A socket event bit rises only from a pulse its mask passed.
- A recorded bit survives unless the host cleared it.
- A simultaneous event beats a clear.
- The line asserts and releases one edge after its cause appears or vanishes.
- The hold-off counter loads the interval on release and keeps the line high while it runs.

Only the bench's scenarios can show the register address map and the read-back values. They also show that writes to the summary are ignored, and the exact high-time lengths across a sweep of interval values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int EVW    = 8;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 8;
  localparam int BLK_W  = ADDR_W - OFF_W;

  localparam logic [OFF_W-1:0] OFF_IVL_HI  = 8'h13;
  localparam logic [OFF_W-1:0] OFF_IVL_LO  = 8'h14;
  localparam logic [OFF_W-1:0] OFF_COM_EVT = 8'h15;
  localparam logic [OFF_W-1:0] OFF_COM_MSK = 8'h16;
  localparam logic [OFF_W-1:0] OFF_SUM     = 8'h17;
  localparam logic [OFF_W-1:0] OFF_SUM_MSK = 8'h18;
  localparam logic [OFF_W-1:0] OFF_SK_EVT  = 8'h02;
  localparam logic [OFF_W-1:0] OFF_SK_MSK  = 8'h2C;

  // Next value of a write-one-to-clear register where fresh events win.
  function automatic logic [EVW-1:0] w1c_next(input logic [EVW-1:0] q,
                                              input logic [EVW-1:0] clr,
                                              input logic [EVW-1:0] set);
    return (q & ~clr) | set;
  endfunction

  // True when any bit is both pending and enabled.
  function automatic logic any_enabled(input logic [EVW-1:0] pend,
                                       input logic [EVW-1:0] en);
    return |(pend & en);
  endfunction
endpackage

// File: rtl/irq_evt_reg.sv
module irq_evt_reg
  import irq_agg_pkg::*;
#(
  parameter bit             GATE_LATCH = 1'b1,
  parameter logic [EVW-1:0] MASK_RST   = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] evt_i,
  input  logic           clr_we,
  input  logic           msk_we,
  input  logic [EVW-1:0] wdata,
  output logic [EVW-1:0] evt_q,
  output logic [EVW-1:0] msk_q,
  output logic           any_o
);
  logic [EVW-1:0] set_bits;
  logic [EVW-1:0] clr_bits;

  generate
    if (GATE_LATCH) begin : g_gated
      assign set_bits = evt_i & msk_q;
    end else begin : g_open
      assign set_bits = evt_i;
    end
  endgenerate

  assign clr_bits = clr_we ? wdata : '0;
  assign any_o    = |evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      msk_q <= MASK_RST;
    end else begin
      evt_q <= w1c_next(evt_q, clr_bits, set_bits);
      if (msk_we) msk_q <= wdata;
    end
  end

  generate
    if (GATE_LATCH) begin : g_gate_chk
      // R2
      latch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q) & ~($past(evt_i) & $past(msk_q))) == '0));
    end
  endgenerate

  // R3
  hold_unless_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_q) & ~$past(clr_bits) & ~evt_q) == '0));

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_bits) & ~evt_q) == '0));
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             act_o
);
  logic [IVL_W-1:0] cnt_q;
  logic             release_ev;
  logic             fire_ev;
  logic             wait_busy;

  assign wait_busy  = (cnt_q != '0);
  assign release_ev = act_o && !pend_i;
  assign fire_ev    = !act_o && pend_i && !wait_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (release_ev) begin
      act_o <= 1'b0;
      cnt_q <= ivl_i;
    end else if (fire_ev) begin
      act_o <= 1'b1;
    end else if (wait_busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6
  assert_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && pend_i && cnt_q == '0) |=> act_o);
  // R7
  release_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && !pend_i) |=> !act_o);
  // R8
  reload_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_o) |-> (cnt_q == $past(ivl_i)));
  // R8
  quiet_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && cnt_q != '0) |=> !act_o);
endmodule

// File: rtl/nic_irq_agg.sv
module nic_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NSOCK = 8,
  parameter int IVL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [EVW-1:0]        reg_wdata,
  output logic [EVW-1:0]        reg_rdata,
  input  logic [NSOCK*EVW-1:0]  sock_evt_i,
  input  logic [EVW-1:0]        com_evt_i,
  output logic                  irq_n
);
  logic [BLK_W-1:0] blk;
  logic [OFF_W-1:0] off;
  logic             shared_hit;
  logic [EVW-1:0]   sk_evt [NSOCK];
  logic [EVW-1:0]   sk_msk [NSOCK];
  logic [NSOCK-1:0] sum_live;
  logic [NSOCK-1:0] sum_msk_q;
  logic [IVL_W-1:0] ivl_q;
  logic [EVW-1:0]   com_evt, com_msk;
  logic [EVW-1:0]   sum_pad, smsk_pad;
  logic             pend;
  logic             act;

  assign blk        = reg_addr[ADDR_W-1:OFF_W];
  assign off        = reg_addr[OFF_W-1:0];
  assign shared_hit = (blk == '0);

  genvar g;
  generate
    for (g = 0; g < NSOCK; g++) begin : g_sock
      logic hit;
      assign hit = (blk == BLK_W'(g + 1));
      irq_evt_reg #(.GATE_LATCH(1'b1), .MASK_RST('1)) u_sock (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (sock_evt_i[g*EVW +: EVW]),
        .clr_we (reg_we && hit && off == OFF_SK_EVT),
        .msk_we (reg_we && hit && off == OFF_SK_MSK),
        .wdata  (reg_wdata),
        .evt_q  (sk_evt[g]),
        .msk_q  (sk_msk[g]),
        .any_o  (sum_live[g])
      );
    end
  endgenerate

  irq_evt_reg #(.GATE_LATCH(1'b0), .MASK_RST('0)) u_common (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (com_evt_i),
    .clr_we (reg_we && shared_hit && off == OFF_COM_EVT),
    .msk_we (reg_we && shared_hit && off == OFF_COM_MSK),
    .wdata  (reg_wdata),
    .evt_q  (com_evt),
    .msk_q  (com_msk),
    .any_o  ()
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_msk_q <= '0;
      ivl_q     <= '0;
    end else if (reg_we && shared_hit) begin
      case (off)
        OFF_SUM_MSK: sum_msk_q <= reg_wdata[NSOCK-1:0];
        OFF_IVL_HI:  ivl_q[IVL_W-1:8] <= reg_wdata[IVL_W-9:0];
        OFF_IVL_LO:  ivl_q[7:0] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    sum_pad  = '0;
    smsk_pad = '0;
    sum_pad[NSOCK-1:0]  = sum_live;
    smsk_pad[NSOCK-1:0] = sum_msk_q;
  end

  assign pend = any_enabled(com_evt, com_msk) || any_enabled(sum_pad, smsk_pad);

  irq_holdoff #(.IVL_W(IVL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .ivl_i  (ivl_q),
    .act_o  (act)
  );

  assign irq_n = ~act;

  always_comb begin
    reg_rdata = '0;
    if (shared_hit) begin
      case (off)
        OFF_IVL_HI:  reg_rdata = ivl_q[IVL_W-1:8];
        OFF_IVL_LO:  reg_rdata = ivl_q[7:0];
        OFF_COM_EVT: reg_rdata = com_evt;
        OFF_COM_MSK: reg_rdata = com_msk;
        OFF_SUM:     reg_rdata = sum_pad;
        OFF_SUM_MSK: reg_rdata = smsk_pad;
        default:     reg_rdata = '0;
      endcase
    end
    for (int i = 0; i < NSOCK; i++) begin
      if (blk == BLK_W'(i + 1)) begin
        if (off == OFF_SK_EVT)      reg_rdata = sk_evt[i];
        else if (off == OFF_SK_MSK) reg_rdata = sk_msk[i];
      end
    end
  end

  // R5
  summary_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_live[0] == (sk_evt[0] != '0)));
  // R6
  line_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(pend));
endmodule

// File: tb/nic_irq_agg_bench.sv
module nic_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [63:0] sock_evt = '0;
  logic [7:0]  com_evt = '0;
  logic        irq_n;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nic_irq_agg u_nic_irq_agg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sock_evt_i(sock_evt),
    .com_evt_i(com_evt), .irq_n(irq_n));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(16'(reg_rdata), 16'(exp), tag);
  endtask

  task automatic pulse_sk(input int s, input int b);
    @(negedge clk);
    sock_evt[s*8+b] = 1'b1;
    @(negedge clk);
    sock_evt = '0;
  endtask

  task automatic pulse_com(input int b);
    @(negedge clk);
    com_evt[b] = 1'b1;
    @(negedge clk);
    com_evt = '0;
  endtask

  function automatic logic [11:0] sk_a(input int s, input logic [7:0] off);
    return 12'((s + 1) << 8) | 12'(off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ivls[5];
    ivls = '{0, 1, 3, 10, 700};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(16'(irq_n), 16'h1, "R1 irq_n");
    rd(12'h015, 8'h00, "R1 common events");
    rd(12'h016, 8'h00, "R1 common mask");
    rd(12'h017, 8'h00, "R1 summary");
    rd(12'h018, 8'h00, "R1 summary mask");
    rd(12'h013, 8'h00, "R1 interval hi");
    rd(12'h014, 8'h00, "R1 interval lo");
    for (int s = 0; s < 8; s++) begin
      rd(sk_a(s, 8'h2C), 8'hFF, "R1 socket mask");
      rd(sk_a(s, 8'h02), 8'h00, "R1 socket events");
    end

    // R10 map and unmapped reads
    wr(12'h013, 8'hA5);
    wr(12'h014, 8'h3C);
    rd(12'h013, 8'hA5, "R10 interval hi");
    rd(12'h014, 8'h3C, "R10 interval lo");
    rd(12'h040, 8'h00, "R10 unmapped shared");
    rd(12'h900, 8'h00, "R10 unmapped block");
    wr(12'h013, 8'h00);
    wr(12'h014, 8'h00);

    // R2 R3 R5 sweep over every socket and bit
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 8; b++) begin
        wr(sk_a(s, 8'h2C), ~(8'h01 << b));
        pulse_sk(s, b);
        rd(sk_a(s, 8'h02), 8'h00, "R2 masked event ignored");
        rd(12'h017, 8'h00, "R5 summary stays clear");
        wr(sk_a(s, 8'h2C), 8'hFF);
        pulse_sk(s, b);
        rd(sk_a(s, 8'h02), 8'h01 << b, "R2 enabled event latched");
        rd(12'h017, 8'h01 << s, "R5 summary follows socket");
        wr(sk_a(s, 8'h02), 8'h00);
        rd(sk_a(s, 8'h02), 8'h01 << b, "R3 write zero keeps");
        wr(12'h017, 8'hFF);
        rd(12'h017, 8'h01 << s, "R5 summary write ignored");
        wr(sk_a(s, 8'h02), 8'h01 << b);
        rd(sk_a(s, 8'h02), 8'h00, "R3 write one clears");
        rd(12'h017, 8'h00, "R5 summary drops");
      end
    end
    wr(sk_a(1, 8'h02), 8'hFF);
    rd(sk_a(1, 8'h02), 8'h00, "R3 write cannot set");

    // R4 common latches regardless of mask, irq stays high while masked
    pulse_com(5);
    rd(12'h015, 8'h20, "R4 common latched while masked");
    chk(16'(irq_n), 16'h1, "R4 masked common no irq");
    wr(12'h015, 8'h20);
    rd(12'h015, 8'h00, "R4 common cleared");

    // R9 set wins over clear
    pulse_com(2);
    @(negedge clk);
    com_evt[2] = 1'b1; reg_addr = 12'h015; reg_wdata = 8'h04; reg_we = 1'b1;
    @(negedge clk);
    com_evt = '0; reg_we = 1'b0;
    rd(12'h015, 8'h04, "R9 common set beats clear");
    wr(12'h015, 8'h04);
    pulse_sk(5, 1);
    @(negedge clk);
    sock_evt[5*8+1] = 1'b1; reg_addr = sk_a(5, 8'h02); reg_wdata = 8'h02; reg_we = 1'b1;
    @(negedge clk);
    sock_evt = '0; reg_we = 1'b0;
    rd(sk_a(5, 8'h02), 8'h02, "R9 socket set beats clear");
    wr(sk_a(5, 8'h02), 8'h02);

    // R6 R7 socket path timing
    wr(12'h018, 8'h04);
    pulse_sk(2, 3);
    chk(16'(irq_n), 16'h1, "R6 one edge after latch");
    @(negedge clk);
    chk(16'(irq_n), 16'h0, "R6 asserted");
    wr(sk_a(2, 8'h02), 8'h08);
    chk(16'(irq_n), 16'h0, "R7 still low on clearing edge");
    @(negedge clk);
    chk(16'(irq_n), 16'h1, "R7 released");
    pulse_sk(4, 0);
    repeat (3) @(negedge clk);
    chk(16'(irq_n), 16'h1, "R6 socket not in summary mask");
    wr(sk_a(4, 8'h02), 8'h01);

    // R8 hold-off sweep
    wr(12'h016, 8'h03);
    foreach (ivls[k]) begin
      int hi_cycles;
      wr(12'h013, 8'(ivls[k] >> 8));
      wr(12'h014, 8'(ivls[k]));
      repeat (ivls[k] + 4) @(negedge clk);
      pulse_com(0);
      @(negedge clk);
      chk(16'(irq_n), 16'h0, "R6 common asserted");
      reg_addr = 12'h015; reg_wdata = 8'h01; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; com_evt[1] = 1'b1;
      @(posedge clk);
      hi_cycles = 0;
      @(negedge clk);
      com_evt = '0;
      while (irq_n === 1'b1 && hi_cycles < ivls[k] + 20) begin
        hi_cycles++;
        @(negedge clk);
      end
      chk(16'(hi_cycles), 16'(ivls[k] + 1), "R8 high time after release");
      wr(12'h015, 8'h02);
    end
    repeat (710) @(negedge clk);
    chk(16'(irq_n), 16'h1, "R7 idle at end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule